// File: doc/BRIEF.md
# Decoupled Counting Presence Filter for Cache Line Addresses

This block keeps an approximate record of which physical line addresses currently sit in a cache. It lets a miss handler skip a costly search for an aliased copy. Each address is reduced to a short index by folding it with XOR. That index selects one small saturating counter and one presence bit. The cache controller sends an update whenever a line is filled (count up) or evicted (count down). The presence bit for an index is written only when its counter leaves zero or returns to zero. No other update touches the bit array.

On a miss, the controller queries the filter with the physical address. The query side carries its own copy of the same fold, so it does not share any logic with the counter side. It reads a single presence bit. A 0 answer guarantees that no resident line hashes to that index, so the alias search can be skipped. A 1 answer means a line may be present and the full search must run.

Both the update port and the query port are valid/ready streams. Neither one ever applies back-pressure: `upd_ready` and `qry_ready` are held high whenever the block is out of reset, and a beat is taken on every cycle in which valid is high. The response is a plain registered pulse and cannot be stalled. The overflow and underflow indications are single-cycle status pulses.

Top module: `lcbf_filter`

## Requirements
- R1: After reset every counter and presence bit is zero, so any query returns `rsp_maybe` = 0 and both status pulses are low.
- R2: The index is the XOR of the address split into IDX_W-bit chunks, with the top chunk zero-padded. With the defaults (32-bit address, 8-bit index), 0x00000012 and 0x00001200 both fold to 0x12, and 0x01020304 folds to 0x04.
- R3: An update beat with `upd_inc` = 1 adds one to the selected counter, and a beat with `upd_inc` = 0 subtracts one from it.
- R4: When a counter goes from 0 to 1, its presence bit becomes 1.
- R5: When a counter goes from 1 to 0, its presence bit becomes 0. Any other count change, such as 2 to 1, leaves the bit unchanged.
- R6: A query beat accepted at a clock edge gives `rsp_valid` = 1 after that edge, with `rsp_maybe` equal to the presence bit at the folded index. `rsp_valid` is 0 in every cycle that follows no query beat.
- R7: An increment at the maximum count (7 for 3-bit counters) leaves the counter at its maximum and raises `ovf_pulse` for exactly one cycle.
- R8: A decrement at count zero is ignored: the counter and the bit stay at 0, and `udf_pulse` rises for exactly one cycle.
- R9: If a query and a presence-bit write target the same index in the same cycle, the response carries the newly written value.
- R10: `upd_ready` and `qry_ready` are 1 whenever reset is released, so every valid beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update beat present |
| upd_ready | output | 1 | Update accepted (always 1 out of reset) |
| upd_inc | input | 1 | 1 = line filled (count up), 0 = line evicted (count down) |
| upd_addr | input | ADDR_W | Physical line address of the update |
| qry_valid | input | 1 | Query beat present |
| qry_ready | output | 1 | Query accepted (always 1 out of reset) |
| qry_addr | input | ADDR_W | Physical line address to test |
| rsp_valid | output | 1 | Response for the query taken at the previous edge |
| rsp_maybe | output | 1 | 0 = definitely absent, 1 = possibly present |
| ovf_pulse | output | 1 | One-cycle pulse: increment hit a saturated counter |
| udf_pulse | output | 1 | One-cycle pulse: decrement hit a zero counter |

## Verification
Two functions can land in the same cycle: a presence-bit write caused by a zero crossing, and a query that folds to the same index. The bench provokes this by issuing a fill or an eviction together with a query whose address aliases the updated one. It checks that the response already shows the new bit value (1 after the first fill, 0 after the last eviction), not the stale one. Other same-cycle cases include a query at an unrelated index alongside an update, and an underflowing decrement together with a query. In these cases the response is checked to reflect only its own index.

// File: rtl/lcbf_pkg.sv
package lcbf_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_IDX_W  = 8;
  localparam int unsigned DEF_CNT_W  = 3;
endpackage

// File: rtl/lcbf_hash.sv
module lcbf_hash #(
  parameter int unsigned ADDR_W = lcbf_pkg::DEF_ADDR_W,
  parameter int unsigned IDX_W  = lcbf_pkg::DEF_IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned NCH = (ADDR_W + IDX_W - 1) / IDX_W;

  logic [NCH*IDX_W-1:0] padded;
  logic [IDX_W-1:0]     part [NCH+1];

  always_comb begin
    padded = '0;
    padded[ADDR_W-1:0] = addr;
  end

  assign part[0] = '0;
  for (genvar i = 0; i < NCH; i++) begin : g_fold
    assign part[i+1] = part[i] ^ padded[i*IDX_W +: IDX_W];
  end

  assign idx = part[NCH];
endmodule

// File: rtl/lcbf_counter_array.sv
module lcbf_counter_array #(
  parameter int unsigned IDX_W = lcbf_pkg::DEF_IDX_W,
  parameter int unsigned CNT_W = lcbf_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             inc,
  input  logic [IDX_W-1:0] idx,
  output logic             vec_we,
  output logic [IDX_W-1:0] vec_idx,
  output logic             vec_val,
  output logic             ovf_q,
  output logic             udf_q
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] old_c;
  logic             at_max, at_zero, rise, fall;

  assign old_c   = cnt_q[idx];
  assign at_max  = (old_c == CMAX);
  assign at_zero = (old_c == '0);
  assign rise    = fire &&  inc && at_zero;
  assign fall    = fire && !inc && (old_c == ONE);

  assign vec_we  = rise || fall;
  assign vec_idx = idx;
  assign vec_val = rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= fire &&  inc && at_max;
      udf_q <= fire && !inc && at_zero;
      if (fire && inc && !at_max)   cnt_q[idx] <= old_c + ONE;
      if (fire && !inc && !at_zero) cnt_q[idx] <= old_c - ONE;
    end
  end

  // R3: counting up by one below saturation
  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && inc && !at_max) |=> (cnt_q[$past(idx)] == $past(old_c) + ONE));
  // R3: counting down by one above zero
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !inc && !at_zero) |=> (cnt_q[$past(idx)] == $past(old_c) - ONE));
  // R7: saturation holds the counter and pulses overflow
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && inc && at_max) |=> (ovf_q && cnt_q[$past(idx)] == CMAX));
  // R8: decrement at zero ignored and pulses underflow
  a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !inc && at_zero) |=> (udf_q && cnt_q[$past(idx)] == '0));
  // R5: no vector write without an update beat
  a_r5_write_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |-> fire);
endmodule

// File: rtl/lcbf_bit_vector.sv
module lcbf_bit_vector #(
  parameter int unsigned IDX_W = lcbf_pkg::DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wval,
  input  logic             qfire,
  input  logic [IDX_W-1:0] qidx,
  output logic             rsp_valid,
  output logic             rsp_maybe
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bits_q;
  logic             hit_now;

  assign hit_now = we && (widx == qidx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_maybe <= 1'b0;
    end else begin
      if (we) bits_q[widx] <= wval;
      rsp_valid <= qfire;
      rsp_maybe <= qfire && (hit_now ? wval : bits_q[qidx]);
    end
  end

  // R4/R5: a requested write lands at its index
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (bits_q[$past(widx)] == $past(wval)));
  // R9: same-index query sees the freshly written value
  a_r9_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (qfire && hit_now) |=> (rsp_valid && rsp_maybe == $past(wval)));
  // R6: response valid follows a query beat only
  a_r6_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !qfire |=> !rsp_valid);
endmodule

// File: rtl/lcbf_filter.sv
module lcbf_filter #(
  parameter int unsigned ADDR_W = lcbf_pkg::DEF_ADDR_W,
  parameter int unsigned IDX_W  = lcbf_pkg::DEF_IDX_W,
  parameter int unsigned CNT_W  = lcbf_pkg::DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic              upd_inc,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              qry_valid,
  output logic              qry_ready,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              rsp_valid,
  output logic              rsp_maybe,
  output logic              ovf_pulse,
  output logic              udf_pulse
);
  logic [IDX_W-1:0] u_idx, q_idx, w_idx;
  logic             w_en, w_val, u_fire, q_fire;

  assign upd_ready = rst_n;
  assign qry_ready = rst_n;
  assign u_fire    = upd_valid && upd_ready;
  assign q_fire    = qry_valid && qry_ready;

  lcbf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_upd (
    .addr(upd_addr), .idx(u_idx));

  lcbf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_qry (
    .addr(qry_addr), .idx(q_idx));

  lcbf_counter_array #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_counters (
    .clk(clk), .rst_n(rst_n), .fire(u_fire), .inc(upd_inc), .idx(u_idx),
    .vec_we(w_en), .vec_idx(w_idx), .vec_val(w_val),
    .ovf_q(ovf_pulse), .udf_q(udf_pulse));

  lcbf_bit_vector #(.IDX_W(IDX_W)) u_vector (
    .clk(clk), .rst_n(rst_n), .we(w_en), .widx(w_idx), .wval(w_val),
    .qfire(q_fire), .qidx(q_idx), .rsp_valid(rsp_valid), .rsp_maybe(rsp_maybe));

  // R10: ports never stall out of reset
  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ready && qry_ready));
  // R7/R8: overflow and underflow cannot pulse together
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_pulse && udf_pulse));
endmodule

// File: tb/lcbf_filter_bench.sv
module lcbf_filter_bench;
  localparam int AW = 32;
  localparam int NSTEP = 18;
  // row: {upd_v, inc, uaddr[32], qry_v, qaddr[32], exp_maybe, exp_ovf, exp_udf, req[4]}
  localparam int RW = 1 + 1 + AW + 1 + AW + 3 + 4;
  localparam logic [31:0] A = 32'h0000_0012;
  localparam logic [31:0] B = 32'h0000_1200;
  localparam logic [31:0] C = 32'h0102_0304;
  localparam logic [31:0] D = 32'h0000_0005;
  localparam logic [31:0] Z = 32'h0;

  localparam logic [RW-1:0] TBL [NSTEP] = '{
    {1'b0, 1'b0, Z, 1'b1, A, 3'b000, 4'd1},  // R1 fresh query absent
    {1'b1, 1'b1, A, 1'b1, A, 3'b100, 4'd9},  // R9 R4 fill + same-index query
    {1'b0, 1'b0, Z, 1'b1, B, 3'b100, 4'd2},  // R2 alias B folds to 0x12
    {1'b0, 1'b0, Z, 1'b1, C, 3'b000, 4'd6},  // R6 unrelated index 0x04
    {1'b1, 1'b1, B, 1'b1, D, 3'b000, 4'd3},  // R3 count 0x12 to 2, query 0x05
    {1'b1, 1'b0, A, 1'b1, A, 3'b100, 4'd5},  // R5 2->1 keeps bit
    {1'b1, 1'b0, A, 1'b1, B, 3'b000, 4'd9},  // R9 R5 1->0 seen same cycle
    {1'b0, 1'b0, Z, 1'b1, A, 3'b000, 4'd5},  // R5 bit stays clear
    {1'b1, 1'b0, D, 1'b1, D, 3'b001, 4'd8},  // R8 decrement at zero
    {1'b1, 1'b1, C, 1'b0, Z, 3'b000, 4'd3},  // R3 C count 1
    {1'b1, 1'b1, C, 1'b0, Z, 3'b000, 4'd3},
    {1'b1, 1'b1, C, 1'b0, Z, 3'b000, 4'd3},
    {1'b1, 1'b1, C, 1'b0, Z, 3'b000, 4'd3},
    {1'b1, 1'b1, C, 1'b0, Z, 3'b000, 4'd3},
    {1'b1, 1'b1, C, 1'b0, Z, 3'b000, 4'd3},
    {1'b1, 1'b1, C, 1'b0, Z, 3'b000, 4'd3},  // C count 7
    {1'b1, 1'b1, C, 1'b0, Z, 3'b010, 4'd7},  // R7 increment at max
    {1'b0, 1'b0, Z, 1'b1, C, 3'b100, 4'd7}   // R7 pulse gone, bit set
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_valid = 1'b0, upd_inc = 1'b0, qry_valid = 1'b0;
  logic [AW-1:0] upd_addr = '0, qry_addr = '0;
  logic upd_ready, qry_ready, rsp_valid, rsp_maybe, ovf_pulse, udf_pulse;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  lcbf_filter u_lcbf_filter (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_inc(upd_inc), .upd_addr(upd_addr), .qry_valid(qry_valid),
    .qry_ready(qry_ready), .qry_addr(qry_addr), .rsp_valid(rsp_valid),
    .rsp_maybe(rsp_maybe), .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic uv, input logic ui, input logic [AW-1:0] ua,
                      input logic qv, input logic [AW-1:0] qa);
    @(negedge clk);
    upd_valid = uv; upd_inc = ui; upd_addr = ua; qry_valid = qv; qry_addr = qa;
    @(posedge clk);
    #1;
    upd_valid = 1'b0; qry_valid = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {rsp_valid, rsp_maybe, ovf_pulse, udf_pulse}, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R10 ready", {2'b00, upd_ready, qry_ready}, 4'b0011);

    for (int s = 0; s < NSTEP; s++) begin
      logic [RW-1:0] r;
      logic qv;
      r = TBL[s];
      qv = r[RW-1-2-AW];
      step(r[RW-1], r[RW-2], r[RW-3 -: AW], qv, r[RW-4-AW -: AW]);
      check($sformatf("R%0d step %0d", r[3:0], s),
            {rsp_valid, rsp_maybe & qv, ovf_pulse, udf_pulse},
            {qv, r[6], r[5], r[4]});
    end

    // R3 R5: seven evictions of C (saturated at 7) drain it to zero
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, C, 1'b0, Z);
    step(1'b0, 1'b0, Z, 1'b1, C);
    check("R5 count 1 still present", {rsp_valid, rsp_maybe, ovf_pulse, udf_pulse}, 4'b1100);
    step(1'b1, 1'b0, C, 1'b1, C);
    check("R9 last eviction forwarded", {rsp_valid, rsp_maybe, ovf_pulse, udf_pulse}, 4'b1000);
    step(1'b1, 1'b0, C, 1'b0, Z);
    check("R8 extra eviction underflows", {rsp_valid, rsp_maybe, ovf_pulse, udf_pulse}, 4'b0001);
    step(1'b0, 1'b0, Z, 1'b1, C);
    check("R8 bit stays clear", {rsp_valid, rsp_maybe, ovf_pulse, udf_pulse}, 4'b1000);

    // R1: reset clears filled state
    step(1'b1, 1'b1, D, 1'b0, Z);
    step(1'b0, 1'b0, Z, 1'b1, D);
    check("R4 D present", {rsp_valid, rsp_maybe, ovf_pulse, udf_pulse}, 4'b1100);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, Z, 1'b1, D);
    check("R1 reset clears bits", {rsp_valid, rsp_maybe, ovf_pulse, udf_pulse}, 4'b1000);
    step(1'b1, 1'b0, D, 1'b0, Z);
    check("R1 reset clears counters", {rsp_valid, rsp_maybe, ovf_pulse, udf_pulse}, 4'b0001);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule